// File: doc/BRIEF.md
# Frequency-Locked Loop Integrator

This block steers a digitally controlled oscillator so that its frequency becomes a programmed multiple of a slow reference clock. It runs on a fast system clock. Both the reference clock and the oscillator clock enter as asynchronous levels, and a synchronizer with edge detection brings each one into the system clock domain. Between two rising reference edges the block counts rising oscillator edges, either directly or after a programmable divider. At each reference edge it compares that count with the target N+1. The 10-bit integrator then moves exactly one step, and it saturates at both ends.

The top five integrator bits choose the oscillator frequency tap. Codes above the highest implemented tap fold onto it. The low five bits go out as the fractional value for a modulator that mixes adjacent taps. Software sets the multiplier, the multiply-by-divider mode and the divider code. It can freeze the loop, and it can overwrite the integrator at any time.

The settled ratio depends on the mode:
- Mode bit clear: the loop settles the oscillator output at (N+1) times the reference.
- Mode bit set: the oscillator clock is divided by D in the feedback path, so the loop settles it at D·(N+1) times the reference.

Top module: `fll_lock_core`

## Requirements
- R1: While reset is asserted, integ_o, tap_o and frac_o are all zero. The first rising reference edge after reset only starts a counting period and never steps the integrator.
- R2: At every later rising reference edge, the integrator decrements by one if the number of feedback pulses counted since the previous rising reference edge is strictly greater than mult_i+1. Otherwise, including when the count is equal, it increments by one.
- R3: With plus_i=0 every rising dco_clk edge is one feedback pulse and dsel_i has no effect. With plus_i=1 one feedback pulse is produced per D rising dco_clk edges, where dsel_i codes 0, 1, 2 and 3 give D = 1, 2, 4 and 8.
- R4: The integrator saturates: a decrement at 0 leaves 0, and an increment at 1023 leaves 1023. It never wraps.
- R5: tap_o equals integ_o[9:5] when that code is below 28, and equals 28 for codes 28 to 31. frac_o always equals integ_o[4:0].
- R6: While hold_i=1, reference-edge steps are suppressed and the integrator keeps its value. Counting continues, so the first reference edge after release steps by the count of a full period.
- R7: A cycle with wr_en_i=1 loads wr_data_i into the integrator, visible after that clock edge. The write wins over a step landing in the same cycle and over hold_i.
- R8: A step caused by a reference edge is visible right after the third rising clock edge, counting the first edge at which ref_clk is sampled high as the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than both sampled clocks |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Reference clock, sampled asynchronously |
| dco_clk | input | 1 | Oscillator output clock, sampled asynchronously |
| mult_i | input | 7 | Multiplier N; the target count per reference period is N+1 |
| plus_i | input | 1 | 1 inserts the D divider in the feedback path |
| dsel_i | input | 2 | Divider code: 0/1/2/3 select D = 1/2/4/8 |
| hold_i | input | 1 | 1 freezes the integrator against loop steps |
| wr_en_i | input | 1 | Direct integrator write strobe |
| wr_data_i | input | 10 | Value loaded on a write |
| integ_o | output | 10 | Integrator word |
| tap_o | output | 5 | Oscillator tap index, 0 to 28 |
| frac_o | output | 5 | Fractional value for the modulator |

## Verification
A software write and a loop step can land on the same clock edge. The same holds for a write and the hold function. The bench provokes the collision by driving the reference clock by hand, which places the synchronized reference edge on a known clock edge, and raising the write strobe so that it is sampled on exactly that edge. The check is that the integrator shows the written value, not that value plus or minus one, with hold both set and clear. A behavioural model mirrors the sampling latency and the divider phase and is compared with all three outputs on every clock, both against fixed-rate oscillator stimulus and against an oscillator whose rate follows the tap and fraction outputs.

// File: rtl/fll_pkg.sv
package fll_pkg;

   // Decision issued by the period comparator once per reference period.
   typedef enum logic [1:0] {
      STEP_NONE = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } fll_step_e;

   // Minimum synchronizer depth accepted for asynchronous clock sampling.
   localparam int FLL_SYNC_MIN = 2;

endpackage

// File: rtl/fll_edge_sync.sv
module fll_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   generate
      if (STAGES < fll_pkg::FLL_SYNC_MIN) begin : g_bad_stages
         $error("fll_edge_sync: STAGES below minimum synchronizer depth");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/fll_fb_divider.sv
module fll_fb_divider #(
   parameter int DSEL_W = 2,
   parameter bit DIV_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              plus_i,
   input  logic [DSEL_W-1:0] dsel_i,
   input  logic              edge_i,
   output logic              pulse_o
);

   // Largest ratio is 2**(2**DSEL_W - 1); the terminal count needs that many bits.
   localparam int CW = (2 ** DSEL_W) - 1;

   generate
      if (DSEL_W < 1) begin : g_bad_dsel
         $error("fll_fb_divider: DSEL_W must be at least 1");
      end

      if (DIV_EN) begin : g_div
         logic [CW-1:0] cnt_q;
         logic [CW-1:0] lim;
         logic          term;

         // Terminal count 2**dsel - 1 as a thermometer of ones.
         always_comb begin
            lim = '0;
            for (int b = 0; b < CW; b++) begin
               lim[b] = (b < int'(dsel_i));
            end
         end

         assign term = (cnt_q >= lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!plus_i) begin
               cnt_q <= '0;
            end else if (edge_i) begin
               if (term) cnt_q <= '0;
               else      cnt_q <= cnt_q + CW'(1);
            end
         end

         assign pulse_o = plus_i ? (edge_i & term) : edge_i;
      end else begin : g_nodiv
         assign pulse_o = edge_i;
      end
   endgenerate

endmodule

// File: rtl/fll_period_cmp.sv
module fll_period_cmp #(
   parameter int MULT_W = 7,
   parameter int CNT_W  = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ref_rise_i,
   input  logic                 fb_pulse_i,
   input  logic [MULT_W-1:0]    mult_i,
   output fll_pkg::fll_step_e   step_o
);

   generate
      if (CNT_W <= MULT_W) begin : g_bad_cnt
         $error("fll_period_cmp: CNT_W must exceed MULT_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] target;
   logic             armed_q;

   assign target = CNT_W'(mult_i) + CNT_W'(1);

   always_comb begin
      step_o = fll_pkg::STEP_NONE;
      if (ref_rise_i && armed_q) begin
         step_o = (cnt_q > target) ? fll_pkg::STEP_DOWN : fll_pkg::STEP_UP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (ref_rise_i) begin
         cnt_q   <= CNT_W'(fb_pulse_i);
         armed_q <= 1'b1;
      end else if (fb_pulse_i && (cnt_q != '1)) begin
         cnt_q   <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/fll_integ_reg.sv
module fll_integ_reg #(
   parameter int INT_W    = 10,
   parameter bit SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  fll_pkg::fll_step_e step_i,
   input  logic               hold_i,
   input  logic               wr_en_i,
   input  logic [INT_W-1:0]   wr_data_i,
   output logic [INT_W-1:0]   integ_o
);

   logic [INT_W-1:0] q;
   logic             at_top;
   logic             at_bot;

   generate
      if (SATURATE) begin : g_sat
         assign at_top = (q == '1);
         assign at_bot = (q == '0);
      end else begin : g_wrap
         assign at_top = 1'b0;
         assign at_bot = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en_i) begin
         q <= wr_data_i;
      end else if (!hold_i) begin
         case (step_i)
            fll_pkg::STEP_UP:   if (!at_top) q <= q + INT_W'(1);
            fll_pkg::STEP_DOWN: if (!at_bot) q <= q - INT_W'(1);
            default:            q <= q;
         endcase
      end
   end

   assign integ_o = q;

endmodule

// File: rtl/fll_tap_map.sv
module fll_tap_map #(
   parameter int INT_W   = 10,
   parameter int TAP_W   = 5,
   parameter int TAP_MAX = 28
) (
   input  logic [INT_W-1:0]       integ_i,
   output logic [TAP_W-1:0]       tap_o,
   output logic [INT_W-TAP_W-1:0] frac_o
);

   localparam int FRAC_W   = INT_W - TAP_W;
   localparam int CODE_TOP = (2 ** TAP_W) - 1;

   generate
      if (FRAC_W < 1) begin : g_bad_split
         $error("fll_tap_map: TAP_W must leave fraction bits");
      end
      if (TAP_MAX > CODE_TOP) begin : g_bad_max
         $error("fll_tap_map: TAP_MAX exceeds tap code range");
      end
   endgenerate

   logic [TAP_W-1:0] code;
   assign code   = integ_i[INT_W-1:FRAC_W];
   assign frac_o = integ_i[FRAC_W-1:0];

   generate
      if (TAP_MAX < CODE_TOP) begin : g_clamp
         assign tap_o = (code > TAP_W'(TAP_MAX)) ? TAP_W'(TAP_MAX) : code;
      end else begin : g_full
         assign tap_o = code;
      end
   endgenerate

endmodule

// File: rtl/fll_lock_core.sv
module fll_lock_core #(
   parameter int INT_W       = 10,
   parameter int TAP_W       = 5,
   parameter int TAP_MAX     = 28,
   parameter int MULT_W      = 7,
   parameter int DSEL_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ref_clk,
   input  logic                   dco_clk,
   input  logic [MULT_W-1:0]      mult_i,
   input  logic                   plus_i,
   input  logic [DSEL_W-1:0]      dsel_i,
   input  logic                   hold_i,
   input  logic                   wr_en_i,
   input  logic [INT_W-1:0]       wr_data_i,
   output logic [INT_W-1:0]       integ_o,
   output logic [TAP_W-1:0]       tap_o,
   output logic [INT_W-TAP_W-1:0] frac_o
);

   localparam int FRAC_W = INT_W - TAP_W;
   localparam int CNT_W  = MULT_W + 2;
   localparam int N_SRC  = 2;

   generate
      if (FRAC_W < 1) begin : g_bad_width
         $error("fll_lock_core: INT_W must exceed TAP_W");
      end
   endgenerate

   logic [N_SRC-1:0] raw_in;
   logic [N_SRC-1:0] rise;
   logic             fb_pulse;
   fll_pkg::fll_step_e step;

   assign raw_in = {dco_clk, ref_clk};

   generate
      for (genvar k = 0; k < N_SRC; k++) begin : g_sync
         fll_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (raw_in[k]),
            .rise_o  (rise[k])
         );
      end
   endgenerate

   fll_fb_divider #(.DSEL_W(DSEL_W), .DIV_EN(1'b1)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .plus_i  (plus_i),
      .dsel_i  (dsel_i),
      .edge_i  (rise[1]),
      .pulse_o (fb_pulse)
   );

   fll_period_cmp #(.MULT_W(MULT_W), .CNT_W(CNT_W)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_rise_i (rise[0]),
      .fb_pulse_i (fb_pulse),
      .mult_i     (mult_i),
      .step_o     (step)
   );

   fll_integ_reg #(.INT_W(INT_W), .SATURATE(1'b1)) u_int (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (step),
      .hold_i    (hold_i),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .integ_o   (integ_o)
   );

   fll_tap_map #(.INT_W(INT_W), .TAP_W(TAP_W), .TAP_MAX(TAP_MAX)) u_map (
      .integ_i (integ_o),
      .tap_o   (tap_o),
      .frac_o  (frac_o)
   );

endmodule

// File: rtl/fll_lock_core_chk.sv
module fll_lock_core_chk #(
   parameter int INT_W   = 10,
   parameter int TAP_W   = 5,
   parameter int TAP_MAX = 28
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hold_i,
   input logic             wr_en_i,
   input logic [INT_W-1:0] wr_data_i,
   input logic [INT_W-1:0] integ_o,
   input logic [TAP_W-1:0] tap_o
);

   // R2: without a write the integrator moves by at most one per clock
   a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en_i) |-> (integ_o == $past(integ_o) ||
                           integ_o == $past(integ_o) + INT_W'(1) ||
                           integ_o == $past(integ_o) - INT_W'(1)));

   // R4: no wrap from the top
   a_r4_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(integ_o) == '1 && !$past(wr_en_i)) |-> integ_o != '0);

   // R4: no wrap from the bottom
   a_r4_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(integ_o) == '0 && !$past(wr_en_i)) |-> integ_o != '1);

   // R5: tap index never exceeds the highest implemented tap
   a_r5_tap_cap: assert property (@(posedge clk) disable iff (!rst_n)
      tap_o <= TAP_W'(TAP_MAX));

   // R6: hold without write keeps the integrator
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hold_i) && !$past(wr_en_i)) |-> $stable(integ_o));

   // R7: a write appears on the next edge
   a_r7_write: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en_i) |-> integ_o == $past(wr_data_i));

endmodule

bind fll_lock_core fll_lock_core_chk #(
   .INT_W   (INT_W),
   .TAP_W   (TAP_W),
   .TAP_MAX (TAP_MAX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hold_i    (hold_i),
   .wr_en_i   (wr_en_i),
   .wr_data_i (wr_data_i),
   .integ_o   (integ_o),
   .tap_o     (tap_o)
);

// File: tb/fll_lock_core_test.sv
module fll_lock_core_test;

   localparam int CLK_PERIOD = 10;
   localparam int REF_PER    = 200;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_clk = 1'b0;
   logic       dco_clk = 1'b0;
   logic [6:0] mult = 7'd30;
   logic       plus = 1'b0;
   logic [1:0] dsel = 2'd1;
   logic       hold = 1'b0;
   logic       wr_en = 1'b0;
   logic [9:0] wr_data = '0;
   logic [9:0] integ;
   logic [4:0] tap;
   logic [4:0] frac;

   fll_lock_core uut (
      .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .dco_clk(dco_clk),
      .mult_i(mult), .plus_i(plus), .dsel_i(dsel), .hold_i(hold),
      .wr_en_i(wr_en), .wr_data_i(wr_data),
      .integ_o(integ), .tap_o(tap), .frac_o(frac)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    n_chk = 0;
   int    n_bad = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   string phase_req = "R1";

   // ---------------- stimulus generator: reference and oscillator ----------
   int        ref_ph = 0;
   bit        ref_man = 1'b0;
   bit        ref_man_val = 1'b0;
   int        dco_ph = 0;
   int        dco_per = 10;
   bit        closed = 1'b0;
   bit [15:0] acc = '0;
   int        eff;

   always @(negedge clk) begin
      ref_ph = (ref_ph + 1) % REF_PER;
      ref_clk <= ref_man ? ref_man_val : (ref_ph >= REF_PER/2);
      if (!closed) begin
         dco_ph = (dco_ph + 1) % dco_per;
         dco_clk <= (dco_ph >= dco_per/2);
      end else begin
         eff = int'(tap) * 32 + int'(frac);
         acc = acc + 16'(600 + 16 * eff);
         dco_clk <= acc[15];
      end
   end

   // ---------------- behavioural reference model --------------------------
   bit rh[4];
   bit dh[4];
   int m_div, m_cnt, m_integ;
   bit m_armed;

   always @(posedge clk) begin
      bit r_rise, d_rise, fb;
      int lim;
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin rh[i] = 0; dh[i] = 0; end
         m_div = 0; m_cnt = 0; m_integ = 0; m_armed = 0;
      end else begin
         for (int i = 3; i > 0; i--) begin rh[i] = rh[i-1]; dh[i] = dh[i-1]; end
         rh[0] = ref_clk;
         dh[0] = dco_clk;
         r_rise = rh[2] && !rh[3];
         d_rise = dh[2] && !dh[3];
         if (!plus) begin
            fb = d_rise;
            m_div = 0;
         end else begin
            lim = (1 << dsel) - 1;
            fb = d_rise && (m_div >= lim);
            if (d_rise) m_div = (m_div >= lim) ? 0 : m_div + 1;
         end
         if (wr_en) m_integ = int'(wr_data);
         else if (r_rise && m_armed && !hold) begin
            if (m_cnt > int'(mult) + 1) m_integ = (m_integ == 0) ? 0 : m_integ - 1;
            else                        m_integ = (m_integ == 1023) ? 1023 : m_integ + 1;
         end
         if (r_rise) begin
            m_cnt = fb ? 1 : 0;
            m_armed = 1;
         end else if (fb && m_cnt < 511) begin
            m_cnt = m_cnt + 1;
         end
      end
   end

   always @(negedge clk) begin
      int et;
      if (rst_n && !done) begin
         et = ((m_integ >> 5) > 28) ? 28 : (m_integ >> 5);
         n_chk++;
         if (int'(integ) != m_integ || int'(tap) != et || int'(frac) != (m_integ & 31)) begin
            n_bad++;
            $display("FAIL %s model: actual integ=%0d tap=%0d frac=%0d expected integ=%0d tap=%0d frac=%0d",
                     phase_req, integ, tap, frac, m_integ, et, m_integ & 31);
         end
      end
   end

   // ---------------- watchdog ---------------------------------------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !done) begin
         done = 1'b1;
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, WATCHDOG);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   // ---------------- helpers ----------------------------------------------
   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wait_ref(input int k);
      repeat (k) @(posedge ref_clk);
      repeat (8) @(negedge clk);
   endtask

   task automatic do_write(input int v);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = 10'(v);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // ---------------- directed sequence ------------------------------------
   initial begin
      int v0;
      repeat (5) @(negedge clk);
      phase_req = "R1";
      chk("R1 reset integ", int'(integ), 0);
      chk("R1 reset tap", int'(tap), 0);
      chk("R1 reset frac", int'(frac), 0);
      @(negedge ref_clk);
      @(negedge clk);
      rst_n = 1'b1;

      // first reference edge only arms; mult=30 with 20 edges steps up
      wait_ref(1);
      chk("R1 first edge no step", int'(integ), 0);
      phase_req = "R2";
      wait_ref(1);
      chk("R2 step up", int'(integ), 1);
      wait_ref(2);
      chk("R2 two more up", int'(integ), 3);

      // count 20 > 11: step down, then saturate at zero
      phase_req = "R4";
      mult = 7'd10;
      wait_ref(3);
      chk("R2 down to zero", int'(integ), 0);
      wait_ref(2);
      chk("R4 hold at zero", int'(integ), 0);

      // writes, top saturation and tap mapping
      phase_req = "R7";
      mult = 7'd30;
      do_write(1023);
      chk("R7 write 1023", int'(integ), 1023);
      chk("R5 tap code 31", int'(tap), 28);
      chk("R5 frac 31", int'(frac), 31);
      wait_ref(2);
      chk("R4 hold at 1023", int'(integ), 1023);
      phase_req = "R5";
      do_write(933);
      chk("R5 tap code 29", int'(tap), 28);
      chk("R5 frac 5", int'(frac), 5);
      do_write(739);
      chk("R5 tap 23", int'(tap), 23);
      chk("R5 frac 3", int'(frac), 3);
      do_write(896);
      chk("R5 tap code 28", int'(tap), 28);
      do_write(895);
      chk("R5 tap 27", int'(tap), 27);
      chk("R5 frac 31 below cap", int'(frac), 31);

      // hold
      phase_req = "R6";
      do_write(200);
      hold = 1'b1;
      wait_ref(3);
      chk("R6 frozen", int'(integ), 200);
      do_write(150);
      chk("R7 write during hold", int'(integ), 150);
      wait_ref(1);
      chk("R6 still frozen", int'(integ), 150);
      hold = 1'b0;
      wait_ref(1);
      chk("R6 resumes", int'(integ), 151);

      // feedback divider
      phase_req = "R3";
      plus = 1'b1; dsel = 2'd2; mult = 7'd4;
      wait_ref(1);
      do_write(500);
      wait_ref(2);
      chk("R3 D=4 equal count up", int'(integ), 502);
      mult = 7'd3;
      wait_ref(2);
      chk("R3 D=4 down", int'(integ), 500);
      dsel = 2'd1; mult = 7'd9;
      wait_ref(1);
      do_write(400);
      wait_ref(2);
      chk("R3 D=2 equal count up", int'(integ), 402);
      mult = 7'd8;
      wait_ref(2);
      chk("R3 D=2 down", int'(integ), 400);
      dsel = 2'd0; mult = 7'd19;
      wait_ref(1);
      do_write(300);
      wait_ref(2);
      chk("R3 D=1 up", int'(integ), 302);
      mult = 7'd18;
      wait_ref(2);
      chk("R3 D=1 down", int'(integ), 300);
      plus = 1'b0; dsel = 2'd3; mult = 7'd19;
      wait_ref(1);
      do_write(300);
      wait_ref(2);
      chk("R3 dsel ignored when plus off", int'(integ), 302);

      // latency with a hand-driven reference edge
      phase_req = "R8";
      mult = 7'd100;
      @(posedge clk); #1;
      ref_man_val = 1'b0; ref_man = 1'b1;
      repeat (120) @(negedge clk);
      v0 = int'(integ);
      @(posedge clk); #1 ref_man_val = 1'b1;
      @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      chk("R8 after first edge", int'(integ), v0);
      @(posedge clk);
      @(negedge clk);
      chk("R8 after second edge", int'(integ), v0);
      @(posedge clk);
      @(negedge clk);
      chk("R8 after third edge", int'(integ), v0 + 1);

      // write colliding with a step
      phase_req = "R7";
      repeat (60) @(negedge clk);
      @(posedge clk); #1 ref_man_val = 1'b0;
      repeat (100) @(negedge clk);
      @(posedge clk); #1 ref_man_val = 1'b1;
      @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_data = 10'd55;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      chk("R7 write beats step", int'(integ), 55);

      // write colliding with a step while hold is set
      repeat (60) @(negedge clk);
      hold = 1'b1;
      @(posedge clk); #1 ref_man_val = 1'b0;
      repeat (100) @(negedge clk);
      @(posedge clk); #1 ref_man_val = 1'b1;
      @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_data = 10'd77;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      chk("R7 write beats hold at step", int'(integ), 77);
      hold = 1'b0;
      @(posedge clk); #1 ref_man = 1'b0;

      // closed loop with an oscillator model driven by tap and fraction
      phase_req = "R2";
      mult = 7'd19; plus = 1'b0;
      @(posedge clk); #1 closed = 1'b1;
      do_write(300);
      wait_ref(150);
      chk_rng("R2 closed loop lock", int'(integ), 340, 430);
      phase_req = "R3";
      plus = 1'b1; dsel = 2'd1; mult = 7'd9;
      wait_ref(40);
      chk_rng("R3 closed loop lock D=2", int'(integ), 340, 430);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule